// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous up-counter built from 4-bit stages, each counting modulo 16 on the rising clock edge. A parallel preset word can be loaded through an active-low load input. Counting is gated by two enables: a parallel enable that every stage sees, and a trickle enable that also gates the terminal-count flag. The active-low reset can be built as asynchronous or synchronous through a parameter.

The top module chains `STAGES` stages. Each stage's terminal-count flag drives the trickle enable of the stage above it. Clock, reset, load and parallel enable are shared by all stages, so the chain counts modulo 16^STAGES as one wide counter. The last stage's terminal-count flag is brought out so that further chains can be cascaded.

Top module: `cascade_counter`

## Requirements
- R1: With reset and load inactive and both enables high, `count_o` increases by one on each rising edge. It wraps from all ones back to zero, and each 4-bit stage by itself counts modulo 16.
- R2: The mode on each edge is chosen in fixed priority: reset first, then load, then increment, then hold.
- R3: With `ASYNC_RST=1`, driving `rst_ni` low forces `count_o` to zero at once, without waiting for a clock edge, whatever the other inputs are.
- R4: With `ASYNC_RST=0`, a low `rst_ni` clears `count_o` to zero on the next rising edge. Until that edge the count is unchanged. Reset overrides both load and increment.
- R5: With reset inactive and `load_ni` low, `data_i` is copied into `count_o` on the next rising edge, whatever the levels of both enables.
- R6: With reset and load inactive, if either `cnt_en_p_i` or `cnt_en_t_i` is low, `count_o` keeps its value across the edge.
- R7: `tc_o` is high exactly when `cnt_en_t_i` is high and every bit of `count_o` is one. It comes straight from the register through logic, with no register of its own. It is low whenever `cnt_en_t_i` is low, even when `cnt_en_p_i` is high.
- R8: Stage k (bits 4k+3..4k) takes as its trickle enable the terminal-count flag of stage k-1. An upper stage therefore advances only on the edge where every lower stage wraps from 15 to 0.
- R9: Apart from the asynchronous reset of R3, `count_o` changes only at rising clock edges. Inputs that change between edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset, asynchronous or synchronous per `ASYNC_RST` |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | 4*STAGES | Preset word |
| cnt_en_p_i | input | 1 | Parallel count enable, shared by all stages |
| cnt_en_t_i | input | 1 | Trickle count enable into stage 0; gates `tc_o` |
| count_o | output | 4*STAGES | Counter value |
| tc_o | output | 1 | Terminal count of the last stage |

## Verification
Two stages are used, giving an 8-bit chain, with one asynchronous and one synchronous instance run side by side. Every preset from 0 to 255 is loaded and then stepped once. This reaches the 15-to-0 carry into the upper nibble and the full wrap from 255. A chain that carried on the wrong condition would skip or repeat upper-nibble values, and a stage with an off-by-one wrap would never return to zero. Reset is asserted together with load and both enables high, and is dropped in the middle of a cycle. An asynchronous build that waited for the edge would keep its old count, and a synchronous build that cleared at once would show zero too early. At a count of 255 the bench drives the trickle enable low with the parallel enable high. A flag gated by the wrong enable, or a register that counted anyway, would be caught there.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR,
    MODE_LOAD,
    MODE_INC,
    MODE_HOLD
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cascade_counter_pkg::*;
(
  input  logic      sync_clr_ni,
  input  logic      load_ni,
  input  logic      en_p_i,
  input  logic      en_t_i,
  output cnt_mode_e mode_o
);
  // fixed priority: clear > load > increment > hold
  always_comb begin
    if (!sync_clr_ni)          mode_o = MODE_CLEAR;
    else if (!load_ni)         mode_o = MODE_LOAD;
    else if (en_p_i && en_t_i) mode_o = MODE_INC;
    else                       mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cascade_counter_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_RST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [WIDTH-1:0] q_o,
  output logic             tc_o
);
  logic [WIDTH-1:0] q_q, q_d;
  logic             sync_clr_n;
  cnt_mode_e        mode;

  // async build clears through the flop, so the decoder never sees a clear
  assign sync_clr_n = ASYNC_RST ? 1'b1 : rst_ni;

  cnt_mode_dec u_dec (
    .sync_clr_ni (sync_clr_n),
    .load_ni     (load_ni),
    .en_p_i      (en_p_i),
    .en_t_i      (en_t_i),
    .mode_o      (mode)
  );

  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_d = '0;
      MODE_LOAD:  q_d = data_i;
      MODE_INC:   q_d = q_q + 1'b1;
      default:    q_d = q_q;
    endcase
  end

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) q_q <= q_d;
    end
  endgenerate

  assign q_o  = q_q;
  assign tc_o = en_t_i & (&q_q);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned STAGE_W   = 4,
  parameter bit          ASYNC_RST = 1'b1,
  localparam int unsigned CNT_W    = STAGES * STAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [CNT_W-1:0] data_i,
  input  logic             cnt_en_p_i,
  input  logic             cnt_en_t_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  // trickle[k] enables stage k; trickle[k+1] is stage k's terminal count
  logic [STAGES:0] trickle;

  assign trickle[0] = cnt_en_t_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cnt_stage #(
      .WIDTH     (STAGE_W),
      .ASYNC_RST (ASYNC_RST)
    ) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_ni (load_ni),
      .data_i  (data_i[k*STAGE_W +: STAGE_W]),
      .en_p_i  (cnt_en_p_i),
      .en_t_i  (trickle[k]),
      .q_o     (count_o[k*STAGE_W +: STAGE_W]),
      .tc_o    (trickle[k+1])
    );
  end

  assign tc_o = trickle[STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned STAGE_W   = 4,
  parameter bit          ASYNC_RST = 1'b1,
  localparam int unsigned CNT_W    = STAGES * STAGE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [CNT_W-1:0] data_i,
  input logic             cnt_en_p_i,
  input logic             cnt_en_t_i,
  input logic [CNT_W-1:0] count_o,
  input logic             tc_o
);
  // R7
  tc_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o == (cnt_en_t_i && (&count_o)));

  // R5
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  // R1
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_p_i && cnt_en_t_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));

  // R6
  hold_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_en_p_i && cnt_en_t_i)) |=> $stable(count_o));

  generate
    if (ASYNC_RST) begin : g_async
      // R3
      async_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |-> count_o == '0);
    end else begin : g_sync
      // R4
      sync_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> count_o == '0);
    end
  endgenerate
endmodule

bind cascade_counter cascade_counter_chk #(
  .STAGES    (STAGES),
  .STAGE_W   (STAGE_W),
  .ASYNC_RST (ASYNC_RST)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .cnt_en_p_i (cnt_en_p_i),
  .cnt_en_t_i (cnt_en_t_i),
  .count_o    (count_o),
  .tc_o       (tc_o)
);

// File: tb/sim_cascade_counter.sv
module sim_cascade_counter;
  localparam int unsigned STAGES = 2;
  localparam int unsigned CNT_W  = STAGES * 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_n = 1'b1;
  logic [CNT_W-1:0] data = '0;
  logic             en_p = 1'b0;
  logic             en_t = 1'b0;
  logic [CNT_W-1:0] cnt_a, cnt_s;
  logic             tc_a, tc_s;

  logic [CNT_W-1:0] exp_cnt = '0;
  logic [15:0]      lf = 16'hACE1;
  int               n_chk = 0;
  int               n_bad = 0;

  always #4 clk = ~clk;

  cascade_counter #(.STAGES(STAGES), .ASYNC_RST(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(en_p), .cnt_en_t_i(en_t), .count_o(cnt_a), .tc_o(tc_a));

  cascade_counter #(.STAGES(STAGES), .ASYNC_RST(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(en_p), .cnt_en_t_i(en_t), .count_o(cnt_s), .tc_o(tc_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] lf_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // drive at negedge, check mid-cycle, then check after the rising edge
  task automatic step(input logic r, input logic l, input logic [CNT_W-1:0] d,
                      input logic ep, input logic et);
    logic [CNT_W-1:0] prev;
    string tag;
    @(negedge clk);
    rst_n = r; load_n = l; data = d; en_p = ep; en_t = et;
    #1;
    if (!r) begin
      chk("R3 async clear before edge", cnt_a, '0);
      chk("R4 sync count kept before edge", cnt_s, exp_cnt);
    end else begin
      chk("R9 async no change between edges", cnt_a, exp_cnt);
      chk("R9 sync no change between edges", cnt_s, exp_cnt);
    end
    prev = exp_cnt;
    if (!r)            begin exp_cnt = '0;            tag = "R2 R4 reset wins"; end
    else if (!l)       begin exp_cnt = d;             tag = "R2 R5 load";       end
    else if (ep && et) begin exp_cnt = prev + 1'b1;   tag = "R1 increment";     end
    else               begin                          tag = "R6 hold";          end
    if (r && l && ep && et && prev[3:0] == 4'hF) tag = {tag, " R8 carry"};
    @(posedge clk);
    #1;
    chk({tag, " async"}, cnt_a, exp_cnt);
    chk({tag, " sync"},  cnt_s, exp_cnt);
    chk("R7 tc async", tc_a, et && (exp_cnt == '1));
    chk("R7 tc sync",  tc_s, et && (exp_cnt == '1));
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // reset state
    @(posedge clk); #1;
    chk("R3 reset state async", cnt_a, '0);
    chk("R4 reset state sync", cnt_s, '0);
    chk("R7 tc after reset", tc_a, 1'b0);
    step(1'b0, 1'b1, '0, 1'b0, 1'b0);

    // every preset, then one increment (covers carry and full wrap)
    for (int v = 0; v < 256; v++) begin
      lf = lf_next(lf);
      step(1'b1, 1'b0, CNT_W'(v), lf[0], lf[1]);
      step(1'b1, 1'b1, lf[15:8], 1'b1, 1'b1);
    end

    // R7: at all ones, trickle low with parallel high
    step(1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
    step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);

    // R8: lower nibble wrap carries into upper nibble
    step(1'b1, 1'b0, 8'h3F, 1'b1, 1'b1);
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);

    // R2: reset together with load and count
    step(1'b1, 1'b0, 8'h37, 1'b1, 1'b1);
    step(1'b0, 1'b0, 8'hAA, 1'b1, 1'b1);
    step(1'b1, 1'b1, 8'hAA, 1'b1, 1'b1);
    // R2: load beats count
    step(1'b1, 1'b0, 8'h5C, 1'b1, 1'b1);

    // mixed pseudo-random run
    for (int i = 0; i < 3000; i++) begin
      lf = lf_next(lf);
      step(lf[3:0] != 4'h0, lf[6:4] != 3'h0, lf[15:8], lf[7] | lf[9], lf[10] | lf[11] | lf[12]);
    end

    summary();
  end
endmodule